// File: doc/BRIEF.md
# Three-Wire Serial Command Port

This block is the slave end of a three-wire serial link that carries command and data bytes into a display controller. It also returns key or switch data to the host. The host drives a shift clock, a strobe and a data-in line. The block drives one return line as an open-drain output: it either pulls the line low or lets it float high. Each serial pin is brought into the local clock domain through synchronizer flops. Edges of the shift clock and of the strobe are then detected on the local clock.

Received bytes are handed to a command decoder as a one-cycle parallel strobe. A flag marks whether the byte is the leading command byte of a strobe frame or a following data byte. When the decoder marks a command as a read, the block requests one outgoing byte per byte slot. It shifts each byte out least significant bit first on the falling edges of the shift clock. Any strobe transition cancels whatever is in progress and readies the port for a new command.

Top module: `sio_cmd_port`

## Requirements
- R1: Data-in is captured on each rising shift-clock edge while strobe is low. Eight captures form one byte, with the first captured bit placed in bit 0. The byte appears on `rx_byte_o` with `rx_valid_o` high for exactly one local clock cycle.
- R2: The first byte completed after strobe falls is presented with `rx_is_cmd_o` = 1.
- R3: Every later byte in the same strobe-low frame is presented with `rx_is_cmd_o` = 0.
- R4: Shift-clock edges while strobe is high produce no byte. They also do not shift the bit alignment of the next frame.
- R5: A rise or a fall of strobe discards any partially received byte and cancels an active read. The next completed byte is again a command.
- R6: If `rd_cmd_i` is 1 in the cycle when a command byte is presented, the port asserts `tx_req_o` in that cycle and latches `tx_byte_i`. Starting at the next falling shift-clock edge, it drives one bit per falling edge, bit 0 first.
- R7: During a read, the port asserts `tx_req_o` on the falling edge that drives bit 7 of the current byte. In that same cycle it latches `tx_byte_i` as the next byte. The next falling edge starts that byte at bit 0.
- R8: The return line is open drain. `sdo_pull_o` = 1 pulls the line low for a 0 bit. `sdo_pull_o` = 0 releases the line for a 1 bit and at all times outside a read.
- R9: `sdo_pull_o` is 0 whenever the synchronized strobe is high, apart from the single cycle in which a strobe rise is first seen.
- R10: While a read is active, bytes clocked in on data-in are not presented on `rx_valid_o`.
- R11: After reset, `rx_valid_o`, `tx_req_o` and `sdo_pull_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial shift clock from host, idles high |
| stb_i | input | 1 | Frame strobe, low during a transfer |
| sdi_i | input | 1 | Serial data in |
| sdo_pull_o | output | 1 | Open-drain control: 1 pulls the return line low |
| rx_valid_o | output | 1 | One-cycle strobe: a received byte is on rx_byte_o |
| rx_byte_o | output | BYTE_W | Last received byte |
| rx_is_cmd_o | output | 1 | Byte on rx_byte_o is the frame's command byte |
| rd_cmd_i | input | 1 | Decoder marks the presented command as a read |
| tx_req_o | output | 1 | Port latches tx_byte_i in this cycle |
| tx_byte_i | input | BYTE_W | Next byte to shift out |

## Verification
The bench sends frames with several commands and then drops the strobe partway through a byte. A port that kept the stray bits would shift every later byte and would lose the command flag. Clock pulses are also sent while the strobe is high. A design that counted them would present bogus bytes or misalign the next frame.

For reads, two consecutive slots are checked against values set just before each reload point. A design that reloaded one edge late would repeat a bit or drop bit 0. A design that inverted the open-drain sense would return complemented data.

The return line is also watched after the strobe rises on a pulled-low bit. It is watched again through a following write frame, to catch a line left stuck low.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef struct packed {
    logic sclk;
    logic stb;
    logic sdi;
  } sio_pins_t;

  localparam sio_pins_t PINS_IDLE = '{sclk: 1'b1, stb: 1'b1, sdi: 1'b0};
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[0] <= RST_VAL;
        else         stg[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sio_rx_shift.sv
module sio_rx_shift #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rise_i,
  input  logic              bit_i,
  input  logic              mute_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              is_cmd_o
);
  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              first_q;
  logic [BYTE_W-1:0] sh_nxt;

  assign sh_nxt = {bit_i, sh_q[BYTE_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      first_q  <= 1'b1;
      valid_o  <= 1'b0;
      byte_o   <= '0;
      is_cmd_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (rise_i) begin
        sh_q <= sh_nxt;
        if (cnt_q == CNT_W'(BYTE_W-1)) begin
          cnt_q    <= '0;
          byte_o   <= sh_nxt;
          valid_o  <= ~mute_i;
          is_cmd_o <= first_q;
          first_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R1: byte strobe lasts one cycle
  a_r1_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R5: strobe edge restarts framing
  a_r5_clr_rearms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0) && first_q && !valid_o);
endmodule

// File: rtl/sio_tx_shift.sv
module sio_tx_shift #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic              fall_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              req_o,
  output logic              active_o,
  output logic              pull_o
);
  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              reload;

  assign reload = active_o & fall_i & (cnt_q == CNT_W'(BYTE_W-1));
  assign req_o  = ~clr_i & (start_i | reload);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      active_o <= 1'b0;
      pull_o   <= 1'b0;
    end else if (clr_i) begin
      cnt_q    <= '0;
      active_o <= 1'b0;
      pull_o   <= 1'b0;
    end else if (start_i) begin
      sh_q     <= byte_i;
      cnt_q    <= '0;
      active_o <= 1'b1;
    end else if (active_o && fall_i) begin
      pull_o <= ~sh_q[0];
      if (reload) begin
        sh_q  <= byte_i;
        cnt_q <= '0;
      end else begin
        sh_q  <= sh_q >> 1;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R6: a granted request leaves the shifter in read mode
  a_r6_req_enters_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> active_o);
  // R8: line only pulled while reading
  a_r8_pull_only_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_o |-> active_o);
endmodule

// File: rtl/sio_cmd_port.sv
module sio_cmd_port
  import sio_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              stb_i,
  input  logic              sdi_i,
  output logic              sdo_pull_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_is_cmd_o,
  input  logic              rd_cmd_i,
  output logic              tx_req_o,
  input  logic [BYTE_W-1:0] tx_byte_i
);
  sio_pins_t pins_s;
  logic      sclk_p, stb_p;
  logic      rise, fall, stb_edge, rd_active, rd_start;

  sio_sync #(
    .W      ($bits(sio_pins_t)),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, stb_i, sdi_i}),
    .q_o   (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sclk_p <= 1'b1;
      stb_p  <= 1'b1;
    end else begin
      sclk_p <= pins_s.sclk;
      stb_p  <= pins_s.stb;
    end

  // clock edges only count inside a frame
  assign rise     = pins_s.sclk & ~sclk_p & ~pins_s.stb;
  assign fall     = ~pins_s.sclk & sclk_p & ~pins_s.stb;
  assign stb_edge = pins_s.stb ^ stb_p;
  assign rd_start = rx_valid_o & rx_is_cmd_o & rd_cmd_i;

  sio_rx_shift #(.BYTE_W(BYTE_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (stb_edge),
    .rise_i  (rise),
    .bit_i   (pins_s.sdi),
    .mute_i  (rd_active),
    .valid_o (rx_valid_o),
    .byte_o  (rx_byte_o),
    .is_cmd_o(rx_is_cmd_o)
  );

  sio_tx_shift #(.BYTE_W(BYTE_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (stb_edge),
    .start_i (rd_start),
    .fall_i  (fall),
    .byte_i  (tx_byte_i),
    .req_o   (tx_req_o),
    .active_o(rd_active),
    .pull_o  (sdo_pull_o)
  );

  // R9: line released while strobe stays high
  a_r9_release_stb_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_p && pins_s.stb) |-> !sdo_pull_o);
  // R10: no bytes presented during a read
  a_r10_mute_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_active |-> !rx_valid_o);
  // R5: strobe edge ends any read
  a_r5_edge_aborts_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_edge |=> !rd_active && !rx_valid_o);
endmodule

// File: tb/sio_cmd_port_bench.sv
`timescale 1ns/1ps
module sio_cmd_port_bench;
  localparam int W = 8;
  localparam time HALF = 80ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b1, stb = 1'b1, sdi = 1'b0, rd_cmd = 1'b0;
  logic [W-1:0] tx_byte = '0;
  logic sdo_pull, rx_valid, rx_is_cmd, tx_req;
  logic [W-1:0] rx_byte;

  int n_chk = 0, n_bad = 0;
  int rx_cnt = 0, req_cnt = 0;
  logic [W-1:0] last_byte = '0;
  logic last_cmd = 1'b0;
  bit done = 0;

  always #2ns clk = ~clk;

  sio_cmd_port u_sio_cmd_port (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .stb_i(stb), .sdi_i(sdi),
    .sdo_pull_o(sdo_pull), .rx_valid_o(rx_valid), .rx_byte_o(rx_byte),
    .rx_is_cmd_o(rx_is_cmd), .rd_cmd_i(rd_cmd), .tx_req_o(tx_req),
    .tx_byte_i(tx_byte)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_cnt++;
      last_byte = rx_byte;
      last_cmd  = rx_is_cmd;
    end
    if (tx_req) req_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one byte slot; next_tx is presented after the slot's first falling edge
  task automatic xfer(input logic [W-1:0] din, input logic [W-1:0] next_tx,
                      output logic [W-1:0] dout);
    for (int i = 0; i < W; i++) begin
      sclk = 1'b0;
      sdi  = din[i];
      #(HALF);
      dout[i] = ~sdo_pull;
      if (i == 0) tx_byte = next_tx;
      sclk = 1'b1;
      #(HALF);
    end
  endtask

  task automatic open_frame();
    stb = 1'b0;
    #(HALF);
  endtask

  task automatic close_frame();
    stb = 1'b1;
    #(2*HALF);
  endtask

  task automatic t_reset();
    chk(!rx_valid && !tx_req && !sdo_pull, "R11", {rx_valid, tx_req, sdo_pull}, 0);
  endtask

  task automatic t_write();
    logic [W-1:0] d;
    int c0 = rx_cnt;
    open_frame();
    xfer(8'h4D, 8'h00, d);
    chk(rx_cnt == c0 + 1 && last_byte == 8'h4D, "R1", last_byte, 8'h4D);
    chk(last_cmd == 1'b1, "R2", last_cmd, 1);
    xfer(8'hA3, 8'h00, d);
    chk(last_byte == 8'hA3 && last_cmd == 1'b0, "R3", {last_cmd, last_byte}, 8'hA3);
    chk(d == 8'hFF, "R8", d, 8'hFF);
    xfer(8'h01, 8'h00, d);
    chk(rx_cnt == c0 + 3 && last_byte == 8'h01 && !last_cmd, "R3", last_byte, 8'h01);
    close_frame();
  endtask

  task automatic t_ignore_idle_clk();
    logic [W-1:0] d;
    int c0 = rx_cnt;
    for (int i = 0; i < 5; i++) begin
      sclk = 1'b0; sdi = i[0]; #(HALF);
      sclk = 1'b1; #(HALF);
    end
    chk(rx_cnt == c0, "R4", rx_cnt - c0, 0);
    open_frame();
    xfer(8'h96, 8'h00, d);
    chk(last_byte == 8'h96 && last_cmd, "R4", last_byte, 8'h96);
    close_frame();
  endtask

  task automatic t_abort();
    logic [W-1:0] d;
    int c0 = rx_cnt;
    open_frame();
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b0; sdi = 1'b1; #(HALF);
      sclk = 1'b1; #(HALF);
    end
    close_frame();
    chk(rx_cnt == c0, "R5", rx_cnt - c0, 0);
    open_frame();
    xfer(8'h5A, 8'h00, d);
    chk(rx_cnt == c0 + 1 && last_byte == 8'h5A && last_cmd, "R5", last_byte, 8'h5A);
    xfer(8'hC3, 8'h00, d);
    chk(last_byte == 8'hC3 && !last_cmd, "R5", last_byte, 8'hC3);
    close_frame();
  endtask

  task automatic t_read();
    logic [W-1:0] d;
    int c0, q0;
    bit stuck;
    rd_cmd  = 1'b1;
    tx_byte = 8'hA5;
    q0 = req_cnt;
    open_frame();
    xfer(8'h42, 8'hA5, d);
    rd_cmd = 1'b0;
    chk(last_cmd && last_byte == 8'h42, "R2", last_byte, 8'h42);
    chk(req_cnt == q0 + 1, "R6", req_cnt - q0, 1);
    c0 = rx_cnt;
    xfer(8'hFF, 8'h3C, d);
    chk(d == 8'hA5, "R6", d, 8'hA5);
    chk(req_cnt == q0 + 2, "R7", req_cnt - q0, 2);
    chk(rx_cnt == c0, "R10", rx_cnt - c0, 0);
    xfer(8'h00, 8'h00, d);
    chk(d == 8'h3C, "R7", d, 8'h3C);
    chk(rx_cnt == c0, "R10", rx_cnt - c0, 0);
    // bit 7 of 0x3C is 0: line should be pulled just before the strobe rises
    chk(sdo_pull == 1'b1, "R8", sdo_pull, 1);
    close_frame();
    chk(sdo_pull == 1'b0, "R9", sdo_pull, 0);
    stuck = 0;
    open_frame();
    for (int i = 0; i < W; i++) begin
      sclk = 1'b0; sdi = 1'b0; #(HALF);
      if (sdo_pull) stuck = 1;
      sclk = 1'b1; #(HALF);
    end
    chk(!stuck, "R5", stuck, 0);
    chk(last_cmd && last_byte == 8'h00, "R5", last_byte, 8'h00);
    close_frame();
  endtask

  initial begin
    #(20ns);
    t_reset();
    rst_n = 1'b1;
    #(40ns);
    t_reset();
    t_write();
    t_ignore_idle_clk();
    t_abort();
    t_read();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4ns);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule